// File: doc/BRIEF.md
# Drive Select and Control Latch

This block holds eight single-bit control flags for a floppy disk interface. Software sets them one at a time over a serial bit-I/O bus. Each bus write carries a bit index from 0 to 7 and one data value. Only the flag at that index takes the new value; the other seven keep theirs. The low four flags drive four board-level lines: recording density, reset of the disk controller, head side, and ROM bank together with the density line.

The upper four flags each request one of four drives. The block turns them into a single drive number from 0 to 4, where 0 means no drive. If several requests are set at once, the drive with the lowest number wins. The drive number falls to 0 only when all four requests are clear. Clearing one request while another is still set moves the selection to the remaining request.

From the drive number the block makes one select line per drive. At most one of these lines is high. The block also forwards the head-side flag, and only to the line of the selected drive. Motor control elsewhere reads the drive number to decide whether a motor may start.

Top module: `drvsel_latch`

## Requirements
- R1: A synchronous active-high `rst` clears all eight flags. After reset `drive_num_o` is 0, `drive_sel_o` and `side_to_drive_o` are all zero, and `latch_q_o` is 0.
- R2: A write with `wr_en` high sets flag `wr_idx` to `wr_bit` at the next clock edge. Every other flag keeps its value. `latch_q_o[k]` shows flag k.
- R3: Flag 0 appears on `density_o`, flag 1 on `ctrl_reset_o`, flag 2 on `side_o`, and flag 3 on `bank_o`.
- R4: Flags 4, 5, 6 and 7 request drives 1, 2, 3 and 4. When more than one request is set, `drive_num_o` is the lowest-numbered requested drive.
- R5: `drive_num_o` is 0 exactly when flags 4 to 7 are all clear. Clearing one request while another stays set leaves the remaining drive selected.
- R6: `drive_sel_o[d]` is high only when `drive_num_o` equals d+1. The vector is zero when `drive_num_o` is 0, and it is never multi-hot.
- R7: `side_to_drive_o[d]` equals flag 2 when drive d+1 is selected and is 0 otherwise. With no drive selected, all of its bits are 0.
- R8: While `wr_en` is low, the flags do not change, whatever `wr_idx` and `wr_bit` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bit-bus write strobe |
| wr_idx | input | 3 | Index of the flag to write |
| wr_bit | input | 1 | Value written to the indexed flag |
| latch_q_o | output | 8 | All eight flags |
| density_o | output | 1 | Density line (flag 0) |
| ctrl_reset_o | output | 1 | Disk controller reset (flag 1) |
| side_o | output | 1 | Head side flag (flag 2) |
| bank_o | output | 1 | ROM bank and density line (flag 3) |
| drive_num_o | output | 3 | Resolved drive number, 0 = none |
| drive_sel_o | output | 4 | One-hot drive select lines |
| side_to_drive_o | output | 4 | Side flag routed to the selected drive only |

## Verification
A write sampled at a rising edge changes the flags at that edge. Every decoded output follows the flags through logic alone, so every result is due one cycle after the write is presented. The bench applies each write at a falling edge and releases the strobe at the following falling edge. It compares every output at that same point, after exactly one rising edge. Idle cycles with noise on the index and data inputs are checked in the same way, one falling edge after the noise is applied.

// File: rtl/drvsel_pkg.sv
package drvsel_pkg;

    localparam int LATCH_W     = 8;
    localparam int IDX_W       = $clog2(LATCH_W);
    localparam int NUM_DRIVES  = 4;
    localparam int DRV_NUM_W   = $clog2(NUM_DRIVES + 1);

    // Flag positions; the drive requests occupy the top NUM_DRIVES flags
    localparam int POS_DENSITY  = 0;
    localparam int POS_CTRL_RST = 1;
    localparam int POS_SIDE     = 2;
    localparam int POS_BANK     = 3;
    localparam int POS_REQ_BASE = LATCH_W - NUM_DRIVES;

    typedef logic [LATCH_W-1:0]    flags_t;
    typedef logic [NUM_DRIVES-1:0] drv_vec_t;
    typedef logic [DRV_NUM_W-1:0]  drv_num_t;

    typedef struct packed {
        logic bank;
        logic side;
        logic ctrl_rst;
        logic density;
    } board_ctrl_t;

    typedef struct packed {
        logic          en;
        logic [IDX_W-1:0] idx;
        logic          value;
    } bit_write_t;

    function automatic board_ctrl_t split_ctrl(input flags_t f);
        board_ctrl_t c;
        c.density  = f[POS_DENSITY];
        c.ctrl_rst = f[POS_CTRL_RST];
        c.side     = f[POS_SIDE];
        c.bank     = f[POS_BANK];
        return c;
    endfunction

    function automatic drv_vec_t request_bits(input flags_t f);
        return f[POS_REQ_BASE +: NUM_DRIVES];
    endfunction

endpackage

// File: rtl/drvsel_bit_latch.sv
module drvsel_bit_latch
    import drvsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bit_write_t wr,
    output flags_t     q
);

    flags_t q_r;

    // Each flag owns its own enable so that only the addressed one moves
    for (genvar k = 0; k < LATCH_W; k++) begin : g_flag
        logic hit;
        assign hit = wr.en && (wr.idx == IDX_W'(k));
        always_ff @(posedge clk) begin
            if (rst) begin
                q_r[k] <= 1'b0;
            end else if (hit) begin
                q_r[k] <= wr.value;
            end
        end
    end

    assign q = q_r;

endmodule

// File: rtl/drvsel_resolver.sv
module drvsel_resolver
    import drvsel_pkg::*;
(
    input  drv_vec_t req,
    output drv_num_t num
);

    // Scan from the highest drive down so the lowest set request lands last
    always_comb begin
        num = '0;
        for (int d = NUM_DRIVES - 1; d >= 0; d--) begin
            if (req[d]) begin
                num = drv_num_t'(d + 1);
            end
        end
    end

endmodule

// File: rtl/drvsel_fanout.sv
module drvsel_fanout
    import drvsel_pkg::*;
(
    input  drv_num_t num,
    input  logic     side,
    output drv_vec_t sel,
    output drv_vec_t side_out
);

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        assign sel[d]      = (num == drv_num_t'(d + 1));
        assign side_out[d] = sel[d] & side;
    end

endmodule

// File: rtl/drvsel_latch.sv
module drvsel_latch
    import drvsel_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_bit,
    output logic [LATCH_W-1:0]    latch_q_o,
    output logic                  density_o,
    output logic                  ctrl_reset_o,
    output logic                  side_o,
    output logic                  bank_o,
    output logic [DRV_NUM_W-1:0]  drive_num_o,
    output logic [NUM_DRIVES-1:0] drive_sel_o,
    output logic [NUM_DRIVES-1:0] side_to_drive_o
);

    bit_write_t  wr;
    flags_t      flags;
    board_ctrl_t ctrl;
    drv_num_t    num;

    assign wr.en    = wr_en;
    assign wr.idx   = wr_idx;
    assign wr.value = wr_bit;

    drvsel_bit_latch u_latch (
        .clk (clk),
        .rst (rst),
        .wr  (wr),
        .q   (flags)
    );

    assign ctrl = split_ctrl(flags);

    drvsel_resolver u_resolve (
        .req (request_bits(flags)),
        .num (num)
    );

    drvsel_fanout u_fanout (
        .num      (num),
        .side     (ctrl.side),
        .sel      (drive_sel_o),
        .side_out (side_to_drive_o)
    );

    assign latch_q_o    = flags;
    assign density_o    = ctrl.density;
    assign ctrl_reset_o = ctrl.ctrl_rst;
    assign side_o       = ctrl.side;
    assign bank_o       = ctrl.bank;
    assign drive_num_o  = num;

endmodule

// File: rtl/drvsel_latch_chk.sv
module drvsel_latch_chk
    import drvsel_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_idx,
    input logic                  wr_bit,
    input logic [LATCH_W-1:0]    latch_q_o,
    input logic                  side_o,
    input logic [DRV_NUM_W-1:0]  drive_num_o,
    input logic [NUM_DRIVES-1:0] drive_sel_o,
    input logic [NUM_DRIVES-1:0] side_to_drive_o
);

    function automatic logic [LATCH_W-1:0] keep_mask(input logic [IDX_W-1:0] i);
        return ~(LATCH_W'(1) << i);
    endfunction

    // R2: the addressed flag takes the written value
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> latch_q_o[$past(wr_idx)] == $past(wr_bit));

    // R2: no other flag moves
    a_r2_others_hold: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((latch_q_o ^ $past(latch_q_o)) & keep_mask($past(wr_idx))) == '0);

    // R8
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(latch_q_o));

    // R4: lowest request wins
    a_r4_first_wins: assert property (@(posedge clk) disable iff (rst)
        latch_q_o[POS_REQ_BASE] |-> drive_num_o == DRV_NUM_W'(1));

    // R5
    a_r5_none_iff_clear: assert property (@(posedge clk) disable iff (rst)
        (latch_q_o[POS_REQ_BASE +: NUM_DRIVES] == '0) == (drive_num_o == '0));

    // R6
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_sel_o) && ((drive_num_o == '0) == (drive_sel_o == '0)));

    // R7
    a_r7_side_gated: assert property (@(posedge clk) disable iff (rst)
        ((side_to_drive_o & ~drive_sel_o) == '0) &&
        ($countones(side_to_drive_o) <= ((side_o) ? 1 : 0)));

endmodule

bind drvsel_latch drvsel_latch_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (wr_en),
    .wr_idx          (wr_idx),
    .wr_bit          (wr_bit),
    .latch_q_o       (latch_q_o),
    .side_o          (side_o),
    .drive_num_o     (drive_num_o),
    .drive_sel_o     (drive_sel_o),
    .side_to_drive_o (side_to_drive_o)
);

// File: tb/drvsel_latch_tb_top.sv
module drvsel_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_idx = '0;
    logic       wr_bit = 1'b0;
    logic [7:0] latch_q_o;
    logic       density_o, ctrl_reset_o, side_o, bank_o;
    logic [2:0] drive_num_o;
    logic [3:0] drive_sel_o, side_to_drive_o;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    logic [7:0] model = '0;

    always #5 clk = ~clk;

    drvsel_latch dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_idx (wr_idx), .wr_bit (wr_bit),
        .latch_q_o (latch_q_o), .density_o (density_o), .ctrl_reset_o (ctrl_reset_o),
        .side_o (side_o), .bank_o (bank_o), .drive_num_o (drive_num_o),
        .drive_sel_o (drive_sel_o), .side_to_drive_o (side_to_drive_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic int want_num(input logic [7:0] m);
        if (m[4])      return 1;
        else if (m[5]) return 2;
        else if (m[6]) return 3;
        else if (m[7]) return 4;
        else           return 0;
    endfunction

    task automatic cmp(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (model=%02h)", req, act, exp, model);
        end
    endtask

    task automatic check_all(input string ctx);
        int n;
        logic [3:0] sel_e;
        n = want_num(model);
        sel_e = (n == 0) ? 4'b0 : 4'(1 << (n - 1));
        cmp({ctx, " R2 flags"}, int'(latch_q_o), int'(model));
        cmp({ctx, " R3 density"}, int'(density_o), int'(model[0]));
        cmp({ctx, " R3 ctrl_reset"}, int'(ctrl_reset_o), int'(model[1]));
        cmp({ctx, " R3 side"}, int'(side_o), int'(model[2]));
        cmp({ctx, " R3 bank"}, int'(bank_o), int'(model[3]));
        cmp({ctx, " R4 R5 drive_num"}, int'(drive_num_o), n);
        cmp({ctx, " R6 drive_sel"}, int'(drive_sel_o), int'(sel_e));
        cmp({ctx, " R7 side_to_drive"}, int'(side_to_drive_o), model[2] ? int'(sel_e) : 0);
    endtask

    task automatic put(input int idx, input logic v);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_idx = 3'(idx);
        wr_bit = v;
        model[idx] = v;
        @(negedge clk);
        wr_en = 1'b0;
        check_all("write");
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model = '0;
        check_all("R1 reset");

        // Every flag pattern reached bit by bit, checked after each write
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < 8; k++) put(k, p[k]);
        end

        // R5: drop requests one at a time from all-set, lowest first
        for (int k = 4; k < 8; k++) put(k, 1'b1);
        put(2, 1'b1);
        for (int k = 4; k < 8; k++) put(k, 1'b0);

        // R8: noise on index and data with strobe low
        model = latch_q_o;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            wr_idx = 3'(i);
            wr_bit = i[3];
            @(negedge clk);
            check_all("R8 idle");
        end

        // Pseudo-random write stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            put(int'(lfsr[2:0]), lfsr[7]);
        end

        // R1: reset from a busy state
        for (int k = 0; k < 8; k++) put(k, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        check_all("R1 reset");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule